// File: doc/BRIEF.md
# Peripheral I/O Bus Bridge

This block connects the data port of a small processor to an external bus of slow peripherals. Each processor access is checked against an address window that covers the top quarter of the 32-bit space (both of the two highest address bits set). An access inside the window becomes a strobed bus transaction. The bridge drives a one-cycle address strobe, qualified by a read strobe or a write strobe. In the same cycle it presents the address, the byte enables and the write data. It then holds those fields until the peripheral answers with ready.

A peripheral that needs more time simply delays ready. Each delayed cycle adds one wait state to the access. When ready arrives, the bridge finishes the access with a one-cycle done pulse to the processor. For a read, it also captures the returned data. While an access is open, the processor side sees busy and new requests are dropped. The shortest access therefore takes three cycles, and at most one access starts every three cycles.

Top module: `iobus_bridge`

## Requirements
- R1: A request on `cpu_req` is claimed only when `cpu_addr[31:30]` equals `2'b11` (addresses 0xC0000000 to 0xFFFFFFFF). Any other address produces no strobe, no busy and no done pulse.
- R2: In the cycle after a claimed request, `bus_as` is high for exactly one cycle. With it, exactly one of `bus_rd` (when `cpu_we`=0) or `bus_wr` (when `cpu_we`=1) is high. `bus_addr`, `bus_be` and `bus_wdata` carry the request's address, byte enables and write data. Neither `bus_rd` nor `bus_wr` is ever high without `bus_as`.
- R3: If the peripheral holds `bus_ready` low for W cycles after the cycle that follows the strobe, `cpu_done` pulses for one cycle exactly 3+W cycles after the cycle in which the request was presented.
- R4: On a read, `cpu_rdata` takes the value of `bus_rdata` from the cycle in which `bus_ready` was high. It keeps that value until the next read completes. Writes leave it unchanged.
- R5: `bus_addr`, `bus_be` and `bus_wdata` stay constant from the strobe cycle until the cycle in which ready is taken.
- R6: `cpu_busy` is high from the strobe cycle through the cycle in which ready is taken. A request presented while `cpu_busy` is high is ignored.
- R7: A high `bus_ready` while no access is outstanding causes no done pulse and no change of `cpu_rdata`.
- R8: A new request presented in the cycle of `cpu_done` is accepted, so consecutive strobes are spaced exactly three cycles apart.
- R9: Reset (`rst` high) abandons any outstanding access. It clears all strobes, `cpu_busy` and `cpu_done`. A ready that arrives after reset for the abandoned access is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access request, one cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Access address |
| cpu_be | input | 4 | Byte enables |
| cpu_wdata | input | 32 | Write data |
| cpu_busy | output | 1 | Bus access outstanding |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data of the last completed read |
| bus_as | output | 1 | Address strobe, one cycle |
| bus_rd | output | 1 | Read qualifier for the strobe |
| bus_wr | output | 1 | Write qualifier for the strobe |
| bus_addr | output | 32 | Bus address |
| bus_be | output | 4 | Bus byte enables |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Read data from peripheral |
| bus_ready | input | 1 | Peripheral completion handshake |

## Verification
Two events can fall in one cycle: the completion of one access (done pulse, busy falling) and the acceptance of the next request. The bench provokes this by presenting a second request exactly in the cycle where the done of a zero-wait access is expected. It judges the result by the done pulse, busy low in that cycle, and the two strobes landing exactly three cycles apart. A second collision is a reset during a long wait state, followed later by the peripheral's late ready. That late ready must leave no done pulse behind.

// File: rtl/iobus_bridge.sv
module iobus_bridge #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int WINDOW_BITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W/8-1:0] cpu_be,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic                cpu_busy,
  output logic                cpu_done,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                bus_as,
  output logic                bus_rd,
  output logic                bus_wr,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic                bus_ready
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [WINDOW_BITS-1:0] WINDOW = '1;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  state_t state;
  logic   is_write;
  logic   claim;

  assign claim    = cpu_req && (state == S_IDLE) &&
                    (cpu_addr[ADDR_W-1 -: WINDOW_BITS] == WINDOW);
  assign cpu_busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      is_write  <= 1'b0;
      bus_as    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_be    <= '0;
      bus_wdata <= '0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      bus_as   <= 1'b0;
      bus_rd   <= 1'b0;
      bus_wr   <= 1'b0;
      cpu_done <= 1'b0;
      unique case (state)
        S_IDLE: if (claim) begin
          state     <= S_ISSUE;
          is_write  <= cpu_we;
          bus_as    <= 1'b1;
          bus_rd    <= !cpu_we;
          bus_wr    <= cpu_we;
          bus_addr  <= cpu_addr;
          bus_be    <= cpu_be;
          bus_wdata <= cpu_wdata;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (bus_ready) begin
          state    <= S_IDLE;
          cpu_done <= 1'b1;
          if (!is_write) cpu_rdata <= bus_rdata;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [BE_W-1:0] unused_be_w;
  assign unused_be_w = '0;
endmodule

// File: rtl/iobus_bridge_chk.sv
module iobus_bridge_chk #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int WINDOW_BITS = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                cpu_busy,
  input logic                cpu_done,
  input logic                bus_as,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W/8-1:0] bus_be,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_ready
);
  assert_window_R1: assert property (@(posedge clk) disable iff (rst)
    bus_as |-> (&bus_addr[ADDR_W-1 -: WINDOW_BITS]));

  assert_one_dir_R2: assert property (@(posedge clk) disable iff (rst)
    bus_as |-> ($countones({bus_rd, bus_wr}) == 1));

  assert_dir_needs_as_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> bus_as);

  assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    bus_as |=> !bus_as);

  assert_done_after_ready_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> ($past(bus_ready) && $past(cpu_busy)));

  assert_fields_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_busy && !bus_as) |->
      ($stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata)));

  assert_strobe_busy_R6: assert property (@(posedge clk) disable iff (rst)
    bus_as |-> cpu_busy);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !cpu_busy);
endmodule

bind iobus_bridge iobus_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WINDOW_BITS(WINDOW_BITS)
) u_chk (
  .clk(clk), .rst(rst), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
  .bus_as(bus_as), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ready(bus_ready)
);

// File: tb/test_iobus_bridge.sv
`timescale 1ns/1ps
module test_iobus_bridge;
  logic        clk = 0;
  logic        rst = 1;
  logic        cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [3:0]  cpu_be = 0;
  logic        cpu_busy, cpu_done;
  logic [31:0] cpu_rdata;
  logic        bus_as, bus_rd, bus_wr;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] per_rdata = 0;
  logic        per_ready = 0, tb_ready = 0;
  logic        bus_ready;
  assign bus_ready = per_ready | tb_ready;

  always #2.5 clk = ~clk;

  iobus_bridge i_iobus_bridge (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_as(bus_as), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(per_rdata),
    .bus_ready(bus_ready)
  );

  typedef struct {
    logic [31:0] addr; logic we; logic [3:0] be;
    logic [31:0] wdata; logic [31:0] rdata; int w;
  } bus_item_t;
  typedef struct { int due; logic we; logic [31:0] rdata; } exp_item_t;

  bus_item_t bus_q[$];
  exp_item_t exp_q[$];
  int tests = 0, fails = 0;
  int cyc = 0, strobes = 0, strobe_cyc = 0, strobe_prev = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && bus_as) strobes <= strobes + 1;
  end

  // Driver: one-cycle request, expected items go to the scoreboard queues
  task automatic issue(input logic [31:0] a, input logic we, input logic [3:0] be,
                       input logic [31:0] wd, input logic [31:0] rd, input int w,
                       input bit on_bus, input bit want_done);
    if (on_bus) bus_q.push_back('{a, we, be, wd, rd, w});
    if (want_done) exp_q.push_back('{cyc + 3 + w, we, rd});
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_be = 0; cpu_wdata = 0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  // Peripheral model: checks strobe fields, inserts wait states, answers
  initial begin
    bus_item_t it;
    forever begin
      @(negedge clk);
      if (!rst && bus_as) begin
        strobe_prev = strobe_cyc;
        strobe_cyc  = cyc;
        if (bus_q.size() == 0) chk(0, "R1 unexpected strobe", bus_addr, 32'h0);
        else begin
          it = bus_q.pop_front();
          chk(bus_addr == it.addr, "R2 address", bus_addr, it.addr);
          chk(bus_rd == !it.we && bus_wr == it.we, "R2 direction",
              {30'd0, bus_rd, bus_wr}, {30'd0, !it.we, it.we});
          chk(bus_be == it.be, "R2 byte enables", {28'd0, bus_be}, {28'd0, it.be});
          if (it.we) chk(bus_wdata == it.wdata, "R2 write data", bus_wdata, it.wdata);
          for (int i = 0; i <= it.w; i++) begin
            @(negedge clk);
            if (i == 0 && !rst) chk(!bus_as, "R2 strobe one cycle", {31'd0, bus_as}, 32'd0);
            if (!rst && cpu_busy)
              chk(bus_addr == it.addr && bus_be == it.be, "R5 fields held",
                  bus_addr, it.addr);
          end
          per_ready = 1; per_rdata = it.rdata;
          @(negedge clk);
          per_ready = 0; per_rdata = 32'hDEAD_BEEF;
        end
      end
    end
  end

  // Monitor: pops the scoreboard on every completion
  always @(negedge clk) begin
    exp_item_t e;
    if (!rst && cpu_done) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected done", 32'd1, 32'd0);
      else begin
        e = exp_q.pop_front();
        chk(cyc == e.due, "R3 done latency", cyc, e.due);
        if (!e.we) chk(cpu_rdata == e.rdata, "R4 read data", cpu_rdata, e.rdata);
      end
    end
  end

  initial begin
    logic [31:0] held;
    int s0;
    repeat (3) @(negedge clk);
    chk(!cpu_busy && !cpu_done && !bus_as && !bus_rd && !bus_wr && cpu_rdata == 0,
        "R9 reset state", {28'd0, cpu_busy, cpu_done, bus_as, bus_rd}, 32'd0);
    rst = 0;
    @(negedge clk);

    issue(32'hC000_0010, 1, 4'hF, 32'h1234_5678, 0, 0, 1, 1);
    chk(cpu_busy, "R6 busy in strobe cycle", {31'd0, cpu_busy}, 32'd1);
    settle();
    issue(32'hFFFF_FFFC, 0, 4'hF, 0, 32'hA5A5_0001, 0, 1, 1);
    settle();
    issue(32'hC000_0000, 0, 4'h3, 0, 32'h0BAD_F00D, 3, 1, 1);
    settle();
    held = cpu_rdata;
    issue(32'hE000_0040, 1, 4'h8, 32'hFFFF_0000, 0, 2, 1, 1);
    settle();
    chk(cpu_rdata == held, "R4 write keeps read data", cpu_rdata, held);

    s0 = strobes;
    issue(32'hBFFF_FFFC, 0, 4'hF, 0, 0, 0, 0, 0);
    chk(!cpu_busy, "R1 miss leaves idle", {31'd0, cpu_busy}, 32'd0);
    issue(32'h0000_1000, 1, 4'hF, 32'h1, 0, 0, 0, 0);
    issue(32'h8000_0000, 0, 4'hF, 0, 0, 0, 0, 0);
    settle();
    chk(strobes == s0, "R1 no strobe outside window", strobes, s0);

    s0 = strobes;
    issue(32'hC000_0100, 0, 4'hF, 0, 32'h5555_AAAA, 4, 1, 1);
    @(negedge clk);
    chk(cpu_busy, "R6 busy while waiting", {31'd0, cpu_busy}, 32'd1);
    cpu_req = 1; cpu_we = 1; cpu_addr = 32'hC000_0200; cpu_be = 4'hF; cpu_wdata = 32'h77;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_be = 0; cpu_wdata = 0;
    settle();
    chk(strobes == s0 + 1, "R6 request while busy ignored", strobes, s0 + 1);

    held = cpu_rdata;
    tb_ready = 1;
    repeat (2) @(negedge clk);
    tb_ready = 0;
    settle();
    chk(cpu_rdata == held, "R7 stray ready ignored", cpu_rdata, held);

    issue(32'hC000_0300, 0, 4'hF, 0, 32'h1111_2222, 0, 1, 1);
    repeat (2) @(negedge clk);
    chk(cpu_done && !cpu_busy, "R8 done cycle is idle",
        {30'd0, cpu_done, cpu_busy}, 32'd2);
    issue(32'hC000_0304, 1, 4'h1, 32'h3333_4444, 0, 0, 1, 1);
    settle();
    chk(strobe_cyc - strobe_prev == 3, "R8 strobe spacing", strobe_cyc - strobe_prev, 3);

    s0 = strobes;
    issue(32'hC000_0400, 0, 4'hF, 0, 32'h9999_0000, 8, 1, 0);
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    chk(!cpu_busy && !bus_as && !bus_rd && !bus_wr && !cpu_done,
        "R9 reset abandons access", {28'd0, cpu_busy, bus_as, bus_rd, cpu_done}, 32'd0);
    rst = 0;
    repeat (15) @(negedge clk);
    chk(!cpu_busy && strobes == s0 + 1, "R9 late ready after reset ignored",
        strobes, s0 + 1);
    chk(exp_q.size() == 0, "R3 all completions seen", exp_q.size(), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule